// File: doc/BRIEF.md
# Sync/Hunt Status Tracker

This block keeps one channel's sync/hunt status bit for a serial controller and raises an external/status interrupt request when that bit changes. The source of the bit depends on the operating mode. In asynchronous mode it mirrors the synchronized sync pin, unless the crystal option forces it to zero. In external-sync mode it is the inverse of the pin. In character-sync mode (monosync or bisync) a hunt flag is set by the hunt command and cleared by a sync-pattern match. In frame mode a hunt flag is set by the hunt command or by a disabled receiver, and cleared by an opening-flag strobe.

When the interrupt enable is 1, the first change of the bit is latched and flagged. The reported value then stays frozen until the CPU acknowledges it with the status-reset strobe. When the enable is 0, the reported value follows the live condition and no request is raised. In character-sync mode the sync pin turns around and becomes an output, which pulses low for one clock on each detected pattern.

Mode encoding on `mode_i`: 0 = asynchronous, 1 = external sync, 2 = character sync, 3 = frame mode.

Top module: `sync_hunt_tracker`

## Requirements
- R1: While reset is asserted and after it is released, `hunt_stat_o` is 1, `irq_o` is 0 and `sync_drv_o` is 1.
- R2: In mode 0 with `xtal_sel_i` = 1, `hunt_stat_o` is 0 and `irq_o` never rises, whatever the pin does.
- R3: In mode 0 with `xtal_sel_i` = 0, `hunt_stat_o` equals the pin level, three clocks after the pin changes.
- R4: In mode 1, `hunt_stat_o` is 0 while the pin is high and 1 while it is low, with the same three-clock latency.
- R5: In mode 2, a hunt pulse sets the status and a sync-match pulse clears it, and hunt wins when both come together. The status follows two clocks after the pulse.
- R6: `sync_oe_o` is 1 only in mode 2. There, `sync_drv_o` goes low for exactly one clock after each sync-match pulse. In every other mode it stays high.
- R7: In mode 3, a hunt pulse or `rx_en_i` = 0 sets the status and an opening-flag pulse clears it, and a set wins over a clear. Sync-match pulses have no effect, so the status stays cleared.
- R8: With `ie_i` = 1, the first change of status raises `irq_o` and freezes `hunt_stat_o`, and later changes are not reported. With `ie_i` = 0, no request is raised and the status stays live.
- R9: Once raised, `irq_o` stays 1 until a `stat_rst_i` pulse.
- R10: `stat_rst_i` clears `irq_o` and the freeze on the next clock. If the live condition then differs from the frozen value, `irq_o` rises again one clock later.
- R11: `xtal_sel_i` has no effect outside mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode (0 async, 1 external sync, 2 character sync, 3 frame) |
| xtal_sel_i | input | 1 | Crystal oscillator option |
| sync_pin_i | input | 1 | Sync pin level (asynchronous to clk) |
| hunt_cmd_i | input | 1 | Enter-hunt command pulse |
| rx_en_i | input | 1 | Receiver enable |
| sync_match_i | input | 1 | Sync pattern detected strobe |
| flag_open_i | input | 1 | Opening flag detected strobe |
| ie_i | input | 1 | Interrupt enable for this status bit |
| stat_rst_i | input | 1 | CPU status reset / acknowledge strobe |
| hunt_stat_o | output | 1 | Reported sync/hunt status |
| irq_o | output | 1 | External/status interrupt request |
| sync_drv_o | output | 1 | Sync pin output level (active low) |
| sync_oe_o | output | 1 | Sync pin output enable |

## Verification
The assertions check on every cycle the rules that hold in any state. A request stays up until acknowledged. An acknowledge always drops it. No request rises with the enable off or under the crystal option. The sync output pulse lasts one clock and is absent outside character-sync mode. The bench scenarios are needed for the rest: the latency and polarity of each mode's status source, the set-over-clear priorities, and the frozen value holding through several intermediate transitions. They also show the re-raise that follows an acknowledge when the live condition has moved.

// File: rtl/sht_pkg.sv
package sht_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_EXT   = 2'd1,
    MODE_CHAR  = 2'd2,
    MODE_FRAME = 2'd3
  } sht_mode_e;
endpackage

// File: rtl/sht_sync_cell.sv
// Multi-stage synchronizer; reset value chosen by parameter.
module sht_sync_cell #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sht_cond_src.sv
// Hunt flag register and per-mode selection of the live status condition.
module sht_cond_src
  import sht_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sht_mode_e mode,
  input  logic      xtal_sel,
  input  logic      pin_s,
  input  logic      hunt_cmd,
  input  logic      rx_en,
  input  logic      sync_match,
  input  logic      flag_open,
  output logic      cond_o,
  output logic      quiet_o
);
  logic hunt_q;
  logic hunt_d;
  logic hunt_set;
  logic hunt_clr;

  always_comb begin
    hunt_set = hunt_cmd || ((mode == MODE_FRAME) && !rx_en);
    hunt_clr = ((mode == MODE_CHAR)  && sync_match) ||
               ((mode == MODE_FRAME) && flag_open);
    hunt_d   = hunt_q;
    if (hunt_set) begin
      hunt_d = 1'b1;
    end else if (hunt_clr) begin
      hunt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunt_q <= 1'b1;
    end else begin
      hunt_q <= hunt_d;
    end
  end

  always_comb begin
    quiet_o = (mode == MODE_ASYNC) && xtal_sel;
    unique case (mode)
      MODE_ASYNC: cond_o = xtal_sel ? 1'b0 : pin_s;
      MODE_EXT:   cond_o = !pin_s;
      default:    cond_o = hunt_q;
    endcase
  end
endmodule

// File: rtl/sht_status_latch.sv
// Reported status, transition latch and interrupt request.
module sht_status_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic quiet,
  input  logic ie,
  input  logic ack,
  output logic stat_o,
  output logic irq_o
);
  logic rep_q, rep_d;
  logic lat_q, lat_d;
  logic irq_q, irq_d;
  logic changed;

  always_comb begin
    rep_d   = rep_q;
    lat_d   = lat_q;
    irq_d   = irq_q;
    changed = (cond != rep_q);
    if (ack) begin
      lat_d = 1'b0;
      irq_d = 1'b0;
    end else if (quiet) begin
      rep_d = 1'b0;
      lat_d = 1'b0;
    end else if (!lat_q) begin
      rep_d = cond;
      if (ie && changed) begin
        lat_d = 1'b1;
        irq_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q <= 1'b1;
      lat_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rep_q <= rep_d;
      lat_q <= lat_d;
      irq_q <= irq_d;
    end
  end

  assign stat_o = rep_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/sht_sync_drive.sv
// Sync pin output side: low pulse per detected pattern in character mode.
module sht_sync_drive
  import sht_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sht_mode_e mode,
  input  logic      sync_match,
  output logic      drv_o,
  output logic      oe_o
);
  logic drv_q, drv_d;
  logic char_mode;

  always_comb begin
    char_mode = (mode == MODE_CHAR);
    drv_d     = !(char_mode && sync_match);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b1;
    end else begin
      drv_q <= drv_d;
    end
  end

  assign drv_o = drv_q;
  assign oe_o  = char_mode;
endmodule

// File: rtl/sync_hunt_tracker.sv
module sync_hunt_tracker
  import sht_pkg::*;
#(
  parameter int PIN_STAGES = 2,
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       xtal_sel_i,
  input  logic       sync_pin_i,
  input  logic       hunt_cmd_i,
  input  logic       rx_en_i,
  input  logic       sync_match_i,
  input  logic       flag_open_i,
  input  logic       ie_i,
  input  logic       stat_rst_i,
  output logic       hunt_stat_o,
  output logic       irq_o,
  output logic       sync_drv_o,
  output logic       sync_oe_o
);
  sht_mode_e mode;
  logic      rst_sync_n;
  logic      pin_s;
  logic      cond;
  logic      quiet;

  assign mode = sht_mode_e'(mode_i);

  sht_sync_cell #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (1'b1),
    .q_o  (rst_sync_n)
  );

  sht_sync_cell #(.STAGES(PIN_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  (sync_pin_i),
    .q_o  (pin_s)
  );

  sht_cond_src u_cond (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mode      (mode),
    .xtal_sel  (xtal_sel_i),
    .pin_s     (pin_s),
    .hunt_cmd  (hunt_cmd_i),
    .rx_en     (rx_en_i),
    .sync_match(sync_match_i),
    .flag_open (flag_open_i),
    .cond_o    (cond),
    .quiet_o   (quiet)
  );

  sht_status_latch u_latch (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cond  (cond),
    .quiet (quiet),
    .ie    (ie_i),
    .ack   (stat_rst_i),
    .stat_o(hunt_stat_o),
    .irq_o (irq_o)
  );

  sht_sync_drive u_drive (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mode      (mode),
    .sync_match(sync_match_i),
    .drv_o     (sync_drv_o),
    .oe_o      (sync_oe_o)
  );
endmodule

// File: rtl/sht_checks.sv
module sht_checks (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       xtal_sel_i,
  input logic       sync_match_i,
  input logic       ie_i,
  input logic       stat_rst_i,
  input logic       irq_o,
  input logic       sync_drv_o
);
  AST_XTAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && xtal_sel_i) |=> !$rose(irq_o)); // R2
  AST_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_i |=> !$rose(irq_o)); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !stat_rst_i) |=> irq_o); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rst_i |=> !irq_o); // R10
  AST_DRV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_drv_o && !(sync_match_i && mode_i == 2'd2)) |=> sync_drv_o); // R6
  AST_DRV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'd2) |=> sync_drv_o); // R6
endmodule

bind sync_hunt_tracker sht_checks u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .xtal_sel_i  (xtal_sel_i),
  .sync_match_i(sync_match_i),
  .ie_i        (ie_i),
  .stat_rst_i  (stat_rst_i),
  .irq_o       (irq_o),
  .sync_drv_o  (sync_drv_o)
);

// File: tb/sync_hunt_tracker_bench.sv
module sync_hunt_tracker_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_i;
  logic       xtal_sel_i, sync_pin_i, hunt_cmd_i, rx_en_i;
  logic       sync_match_i, flag_open_i, ie_i, stat_rst_i;
  logic       hunt_stat_o, irq_o, sync_drv_o, sync_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sync_hunt_tracker u_sync_hunt_tracker (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .xtal_sel_i(xtal_sel_i),
    .sync_pin_i(sync_pin_i), .hunt_cmd_i(hunt_cmd_i), .rx_en_i(rx_en_i),
    .sync_match_i(sync_match_i), .flag_open_i(flag_open_i), .ie_i(ie_i),
    .stat_rst_i(stat_rst_i), .hunt_stat_o(hunt_stat_o), .irq_o(irq_o),
    .sync_drv_o(sync_drv_o), .sync_oe_o(sync_oe_o)
  );

  // [13:12] mode [11] xtal [10] pin [9] hunt [8] rx_en [7] match [6] flag
  // [5] ie [4] stat_rst | expected [3] stat [2] irq [1] drv [0] oe
  localparam int NV = 45;
  localparam logic [13:0] VEC [0:NV-1] = '{
    14'b10_0_1_0_1_0_0_0_0_1_0_1_1, // 0  R5 idle hunt
    14'b10_0_1_0_1_1_0_0_0_1_0_0_1, // 1  R6 match pulse
    14'b10_0_1_0_1_0_0_0_0_0_0_1_1, // 2  R5 cleared
    14'b10_0_1_1_1_0_0_0_0_0_0_1_1, // 3  R5 hunt
    14'b10_0_1_0_1_0_0_0_0_1_0_1_1, // 4  R5 set
    14'b10_0_1_0_1_1_0_1_0_1_0_0_1, // 5  R8 ie on, match
    14'b10_0_1_0_1_0_0_1_0_0_1_1_1, // 6  R8 irq raised
    14'b10_0_1_1_1_0_0_1_0_0_1_1_1, // 7  R8 frozen
    14'b10_0_1_0_1_0_0_1_0_0_1_1_1, // 8  R8 frozen
    14'b10_0_1_0_1_1_0_1_0_0_1_0_1, // 9  R9 held
    14'b10_0_1_0_1_0_0_1_1_0_0_1_1, // 10 R10 ack
    14'b10_0_1_0_1_0_0_1_0_0_0_1_1, // 11 R10 no change
    14'b10_0_1_1_1_0_0_1_0_0_0_1_1, // 12 R8 hunt
    14'b10_0_1_0_1_0_0_1_0_1_1_1_1, // 13 R8 raise
    14'b10_0_1_0_1_1_0_1_0_1_1_0_1, // 14 R9 held
    14'b10_0_1_0_1_0_0_1_1_1_0_1_1, // 15 R10 ack
    14'b10_0_1_0_1_0_0_1_0_0_1_1_1, // 16 R10 re-raise
    14'b10_0_1_0_1_0_0_0_1_0_0_1_1, // 17 R10 ack
    14'b11_0_1_0_1_0_0_0_0_0_0_1_0, // 18 R7 frame
    14'b11_0_1_0_0_0_0_0_0_0_0_1_0, // 19 R7 rx off
    14'b11_0_1_0_1_0_0_0_0_1_0_1_0, // 20 R7 set
    14'b11_0_1_0_1_0_1_0_0_1_0_1_0, // 21 R7 flag
    14'b11_0_1_0_1_0_0_0_0_0_0_1_0, // 22 R7 cleared
    14'b11_0_1_0_1_1_0_0_0_0_0_1_0, // 23 R7 match ignored
    14'b11_0_1_0_1_0_0_0_0_0_0_1_0, // 24 R7 still clear
    14'b11_0_1_1_1_0_1_0_0_0_0_1_0, // 25 R7 set wins
    14'b11_0_1_0_1_0_0_0_0_1_0_1_0, // 26 R7 set
    14'b01_0_1_0_1_0_0_0_0_0_0_1_0, // 27 R4 pin high
    14'b01_0_0_0_1_0_0_0_0_0_0_1_0, // 28 R4
    14'b01_0_0_0_1_0_0_0_0_0_0_1_0, // 29 R4
    14'b01_0_0_0_1_0_0_0_0_1_0_1_0, // 30 R4 pin low seen
    14'b01_0_1_1_1_0_0_0_0_1_0_1_0, // 31 R4
    14'b01_0_1_0_1_0_0_0_0_1_0_1_0, // 32 R4
    14'b01_0_1_0_1_0_0_0_0_0_0_1_0, // 33 R4 pin high seen
    14'b00_0_1_0_1_0_0_1_0_1_1_1_0, // 34 R3 mirror, irq
    14'b00_0_0_0_1_0_0_1_0_1_1_1_0, // 35 R3
    14'b00_0_0_0_1_0_0_1_1_1_0_1_0, // 36 R10 ack
    14'b00_0_0_0_1_0_0_1_0_0_1_1_0, // 37 R3 low seen
    14'b00_0_0_0_1_0_0_0_1_0_0_1_0, // 38 R10 ack
    14'b00_1_1_0_1_0_0_1_0_0_0_1_0, // 39 R2 xtal
    14'b00_1_1_0_1_0_0_1_0_0_0_1_0, // 40 R2
    14'b00_1_1_0_1_0_0_1_0_0_0_1_0, // 41 R2 pin high masked
    14'b00_1_0_0_1_0_0_1_0_0_0_1_0, // 42 R2
    14'b00_1_1_0_1_0_0_1_0_0_0_1_0, // 43 R2
    14'b10_1_1_0_1_0_0_0_0_1_0_1_1  // 44 R11 xtal ignored
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {stat,irq,drv,oe} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle_char();
    mode_i = 2'd2; xtal_sel_i = 1'b0; sync_pin_i = 1'b1; hunt_cmd_i = 1'b0;
    rx_en_i = 1'b1; sync_match_i = 1'b0; flag_open_i = 1'b0; ie_i = 1'b0;
    stat_rst_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    idle_char();
    repeat (3) @(negedge clk);
    check("R1 in reset", {hunt_stat_o, irq_o, sync_drv_o, sync_oe_o}, 4'b1011);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release", {hunt_stat_o, irq_o, sync_drv_o, sync_oe_o}, 4'b1011);

    for (int i = 0; i < NV; i++) begin
      {mode_i, xtal_sel_i, sync_pin_i, hunt_cmd_i, rx_en_i, sync_match_i,
       flag_open_i, ie_i, stat_rst_i} = VEC[i][13:4];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("vector %0d", i),
            {hunt_stat_o, irq_o, sync_drv_o, sync_oe_o}, VEC[i][3:0]);
    end

    // R8: with ie off the status follows the condition and irq stays low
    idle_char();
    hunt_cmd_i = 1'b0; sync_match_i = 1'b1;
    @(posedge clk); @(negedge clk);
    sync_match_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 live with ie off", {hunt_stat_o, irq_o, sync_drv_o, sync_oe_o}, 4'b0011);

    // R1: reset in the middle of operation restores the reset state
    ie_i = 1'b1; hunt_cmd_i = 1'b1;
    @(posedge clk); @(negedge clk);
    hunt_cmd_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 raise before reset", {hunt_stat_o, irq_o, sync_drv_o, sync_oe_o}, 4'b1111);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {hunt_stat_o, irq_o, sync_drv_o, sync_oe_o}, 4'b1011);
    @(negedge clk);
    rst_n = 1'b1;
    idle_char();
    repeat (4) @(negedge clk);
    check("R1 after second release", {hunt_stat_o, irq_o, sync_drv_o, sync_oe_o}, 4'b1011);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule